// File: doc/BRIEF.md
# Ping-Pong Block DMA Channel

A single DMA channel that copies data, one item at a time, between one peripheral data register and a buffer in dedicated DMA RAM. Each item is 16 bits or 8 bits wide, and it moves in either direction. A transfer starts when the selected line of a 32-line peripheral request bus pulses, or when software pulses a force input. The channel counts the transfers it has made in the current block and compares that count with a programmed block length. At the end of a block it stops (one-shot), reloads its start address (continuous), or switches to the other of two buffers (ping-pong).

Each transfer has a read phase on the source port and a write phase on the destination port. Both ports are simple request/ready buses. The RAM address comes from an internal pointer. After each transfer the pointer can step forward by one item or stay where it is. An interrupt pulse marks the end of a block, or the halfway point when that option is chosen. Two sticky flags report a CPU write that lands in the same cycle as the channel's own write, one flag for the RAM and one for the peripheral register. Arming the channel loads the start address, clears the count, the held request and both flags, and enables the channel.

Top module: `dma_pp_channel`

## Requirements
- R1: After reset, `active`, `irq`, `err_ram`, `err_per`, `ppbuf`, `ram_req` and `per_req` are all 0.
- R2: With `cfg_to_per`=0, each transfer reads `per_rdata` and writes it to RAM. In word mode (`cfg_byte`=0) the write uses `ram_be`=2'b11 and the pointer steps by 2. In byte mode the low data byte goes out on both lanes, `ram_be` is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1, and the pointer steps by 1.
- R3: With `cfg_inc`=0, every transfer of the block uses the same RAM address.
- R4: With `cfg_to_per`=1, each transfer reads RAM and writes the peripheral register. In byte mode the upper RAM byte is taken when address bit 0 is 1 and the lower byte when it is 0, and the byte is zero-extended to 16 bits.
- R5: A block is `cfg_len`+1 transfers. In one-shot mode (`cfg_cont`=0, `cfg_pingpong`=0), `active` drops when the block ends, and later requests cause no transfer.
- R6: In continuous mode (`cfg_cont`=1, `cfg_pingpong`=0), the pointer reloads to `cfg_start_a` after each block and `active` stays 1.
- R7: In ping-pong mode, blocks alternate between `cfg_start_a` and `cfg_start_b`, starting with A. `ppbuf` (0 for A, 1 for B) toggles at each block end. With `cfg_cont`=0 the channel stops after a B block. With `cfg_cont`=1 it returns to A and keeps running.
- R8: Only `req_lines[cfg_sel]` or `sw_force` starts a transfer. Requests that arrive while `active`=0 are dropped and are not held.
- R9: `irq` is a one-cycle pulse in the cycle after the write handshake of the last transfer of a block. With `cfg_half`=1 it pulses only after the transfer whose zero-based index equals `cfg_len`/2 (rounded down).
- R10: A request that arrives during a transfer is held and starts one further transfer. Any number of requests during one transfer is held as a single request.
- R11: While the ready of the port in use is low, that port's request and address stay stable, and no transfer completes.
- R12: `err_ram` sets when `cpu_ram_we` is high in a cycle where the channel's RAM write is accepted. `err_per` sets when `cpu_per_we` is high in a cycle where the channel's peripheral write is accepted. Both flags stay set until `cfg_arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_arm | input | 1 | Pulse: load start address, clear state and flags, enable the channel |
| cfg_byte | input | 1 | 1 = byte transfers, 0 = word transfers |
| cfg_to_per | input | 1 | 1 = RAM to peripheral, 0 = peripheral to RAM |
| cfg_inc | input | 1 | Step the RAM pointer after each transfer |
| cfg_cont | input | 1 | Continuous block mode |
| cfg_pingpong | input | 1 | Alternate between the two buffers |
| cfg_half | input | 1 | Interrupt at the half block instead of the block end |
| cfg_sel | input | SELW (5) | Request line select |
| cfg_len | input | CW (10) | Transfers per block minus one |
| cfg_start_a | input | AW (11) | Buffer A byte start address |
| cfg_start_b | input | AW (11) | Buffer B byte start address |
| sw_force | input | 1 | Software trigger pulse |
| req_lines | input | NREQ (32) | Peripheral request lines |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | AW (11) | RAM byte address |
| ram_be | output | 2 | RAM byte-lane enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data |
| ram_rdy | input | 1 | RAM accepts the access this cycle |
| per_req | output | 1 | Peripheral register access request |
| per_we | output | 1 | Peripheral write (1) or read (0) |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |
| per_rdy | input | 1 | Peripheral accepts the access this cycle |
| cpu_ram_we | input | 1 | CPU is writing DMA RAM this cycle |
| cpu_per_we | input | 1 | CPU is writing the peripheral register this cycle |
| active | output | 1 | Channel enabled |
| ppbuf | output | 1 | Active buffer: 0 = A, 1 = B |
| irq | output | 1 | Block-end or half-block interrupt pulse |
| err_ram | output | 1 | Sticky RAM write collision flag |
| err_per | output | 1 | Sticky peripheral write collision flag |

## Verification
The bench counts latency from the clock edge that samples a request. With both readies high, the read handshake happens at the next edge and the write handshake at the edge after that. The pointer, the count, `ppbuf`, `active` and `irq` all change at that write edge, so `irq` is high during the cycle that follows it. The bench drives stimulus on falling edges and then waits five full cycles after each request before it compares memory contents, counters or flags. That wait covers both handshakes and the `irq` pulse. Stall tests hold ready low for longer than a transfer takes, then release it and wait the same margin again before checking.

// File: rtl/dma_pp_pkg.sv
// Shared types for the ping-pong DMA channel.
package dma_pp_pkg;
    localparam int DATA_W = 16;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xfer_st_e;
endpackage

// File: rtl/dma_trig_sel.sv
// Picks one request line out of the request bus, merges it with the software
// trigger, and holds one request that arrives while a transfer is busy.
// Assumes: start is only high while idle, and busy is only high outside idle.
module dma_trig_sel #(
    parameter int NREQ = 32,
    parameter int SELW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            active,
    input  logic [NREQ-1:0] req_lines,
    input  logic [SELW-1:0] sel,
    input  logic            sw_force,
    input  logic            busy,
    input  logic            start,
    output logic            want
);
    logic trig;
    logic pend;

    // Trigger this cycle: the selected line or the force bit, only while enabled.
    always_comb trig = active & (req_lines[sel] | sw_force);
    always_comb want = pend | trig;

    // Held-request flag: set while busy, used up by a start, kept if a new one lands then.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (arm)   pend <= 1'b0;
        else if (busy)  pend <= pend | trig;
        else if (start) pend <= pend & trig;
    end

    a_r10_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && trig && !arm |=> pend);
endmodule

// File: rtl/dma_addr_gen.sv
// RAM pointer and ping-pong buffer select. Steps the pointer after each
// transfer and reloads it at block end, from buffer A or B.
// Assumes: start addresses are aligned to the item size.
module dma_addr_gen #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] start_a,
    input  logic [AW-1:0] start_b,
    input  logic          byte_m,
    input  logic          inc,
    input  logic          pingpong,
    input  logic          done,
    input  logic          blk_end,
    output logic [AW-1:0] addr,
    output logic          ppbuf
);
    logic [AW-1:0] step;

    // Pointer step: one byte or one 16-bit word.
    always_comb step = {{(AW-2){1'b0}}, (byte_m ? 2'b01 : 2'b10)};

    // Pointer and buffer select update on arm, at block end, and after each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            ppbuf <= 1'b0;
        end else if (arm) begin
            addr  <= start_a;
            ppbuf <= 1'b0;
        end else if (done && blk_end) begin
            if (pingpong) begin
                ppbuf <= ~ppbuf;
                addr  <= ppbuf ? start_a : start_b;
            end else begin
                addr  <= start_a;
            end
        end else if (done && inc) begin
            addr <= addr + step;
        end
    end

    a_r7_pp_toggle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ppbuf) |-> $past(arm) || $past(done && blk_end && pingpong));
endmodule

// File: rtl/dma_blk_count.sv
// Counts the transfers in the current block, flags the last one, and makes
// the block-end or half-block interrupt pulse.
// Assumes: len does not change while the channel is armed.
module dma_blk_count #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [CW-1:0] len,
    input  logic          half_en,
    input  logic          done,
    output logic          blk_end,
    output logic          irq
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] half_pt;

    // Last transfer and half point, both taken from the length register.
    always_comb begin
        blk_end = (cnt == len);
        half_pt = len >> 1;
    end

    // Transfer counter: restarts on arm and at every block end.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (arm)  cnt <= '0;
        else if (done) cnt <= blk_end ? '0 : cnt + 1'b1;
    end

    // Interrupt pulse, registered so it follows the completing transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done && (half_en ? (cnt == half_pt) : blk_end);
    end

    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/dma_pp_channel.sv
// One DMA channel: a read phase on the source port, then a write phase on the
// destination port, per triggered transfer. Includes block modes, ping-pong
// buffers, interrupt and write-collision flags.
// Assumes: direction, size and mode inputs stay stable while the channel is armed.
module dma_pp_channel
    import dma_pp_pkg::*;
#(
    parameter int NREQ = 32,
    parameter int SELW = $clog2(NREQ),
    parameter int AW   = 11,
    parameter int CW   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_arm,
    input  logic              cfg_byte,
    input  logic              cfg_to_per,
    input  logic              cfg_inc,
    input  logic              cfg_cont,
    input  logic              cfg_pingpong,
    input  logic              cfg_half,
    input  logic [SELW-1:0]   cfg_sel,
    input  logic [CW-1:0]     cfg_len,
    input  logic [AW-1:0]     cfg_start_a,
    input  logic [AW-1:0]     cfg_start_b,
    input  logic              sw_force,
    input  logic [NREQ-1:0]   req_lines,
    output logic              ram_req,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [1:0]        ram_be,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              ram_rdy,
    output logic              per_req,
    output logic              per_we,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_rdy,
    input  logic              cpu_ram_we,
    input  logic              cpu_per_we,
    output logic              active,
    output logic              ppbuf,
    output logic              irq,
    output logic              err_ram,
    output logic              err_per
);
    xfer_st_e          st;
    logic              want, start, busy, rd_ok, done, blk_end;
    logic [DATA_W-1:0] dbuf, rd_val;

    // Phase decode: which port is in use, and whether this phase is accepted.
    always_comb begin
        busy    = (st != ST_IDLE);
        start   = (st == ST_IDLE) && active && want;
        ram_req = ((st == ST_READ) && cfg_to_per) || ((st == ST_WRITE) && !cfg_to_per);
        per_req = ((st == ST_READ) && !cfg_to_per) || ((st == ST_WRITE) && cfg_to_per);
        ram_we  = (st == ST_WRITE);
        per_we  = (st == ST_WRITE);
        rd_ok   = (st == ST_READ) && (cfg_to_per ? ram_rdy : per_rdy);
        done    = (st == ST_WRITE) && (cfg_to_per ? per_rdy : ram_rdy);
    end

    // Read data: byte lane chosen by address bit 0, zero-extended in byte mode.
    always_comb begin
        if (cfg_to_per)
            rd_val = cfg_byte ? {8'h00, (ram_addr[0] ? ram_rdata[15:8] : ram_rdata[7:0])} : ram_rdata;
        else
            rd_val = cfg_byte ? {8'h00, per_rdata[7:0]} : per_rdata;
    end

    // Write data and lane enables for the destination.
    always_comb begin
        ram_wdata = cfg_byte ? {dbuf[7:0], dbuf[7:0]} : dbuf;
        ram_be    = cfg_byte ? (ram_addr[0] ? 2'b10 : 2'b01) : 2'b11;
        per_wdata = dbuf;
    end

    // Transfer sequencer: idle, then read, then write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_arm) st <= ST_IDLE;
        else begin
            case (st)
                ST_IDLE:  if (start) st <= ST_READ;
                ST_READ:  if (rd_ok) st <= ST_WRITE;
                ST_WRITE: if (done)  st <= ST_IDLE;
                default:             st <= ST_IDLE;
            endcase
        end
    end

    // Data holding register between the read phase and the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     dbuf <= '0;
        else if (rd_ok) dbuf <= rd_val;
    end

    // Channel enable: set on arm, cleared when the final block of a one-shot run ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (cfg_arm) active <= 1'b1;
        else if (done && blk_end && !cfg_cont && (!cfg_pingpong || ppbuf)) active <= 1'b0;
    end

    // Sticky write-collision flags, cleared on arm.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_arm) begin
            err_ram <= 1'b0;
            err_per <= 1'b0;
        end else begin
            if (ram_req && ram_we && ram_rdy && cpu_ram_we) err_ram <= 1'b1;
            if (per_req && per_we && per_rdy && cpu_per_we) err_per <= 1'b1;
        end
    end

    dma_trig_sel #(.NREQ(NREQ), .SELW(SELW)) i_trig (
        .clk(clk), .rst_n(rst_n), .arm(cfg_arm), .active(active),
        .req_lines(req_lines), .sel(cfg_sel), .sw_force(sw_force),
        .busy(busy), .start(start), .want(want));

    dma_addr_gen #(.AW(AW)) i_addr (
        .clk(clk), .rst_n(rst_n), .arm(cfg_arm), .start_a(cfg_start_a),
        .start_b(cfg_start_b), .byte_m(cfg_byte), .inc(cfg_inc),
        .pingpong(cfg_pingpong), .done(done), .blk_end(blk_end),
        .addr(ram_addr), .ppbuf(ppbuf));

    dma_blk_count #(.CW(CW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .arm(cfg_arm), .len(cfg_len),
        .half_en(cfg_half), .done(done), .blk_end(blk_end), .irq(irq));

    a_r11_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req && !ram_rdy && !cfg_arm |=> ram_req && $stable(ram_addr));

    a_r5_oneshot_off: assert property (@(posedge clk) disable iff (!rst_n)
        done && blk_end && !cfg_cont && !cfg_pingpong && !cfg_arm |=> !active);
endmodule

// File: tb/test_dma_pp_channel.sv
module test_dma_pp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_arm = 0, cfg_byte = 0, cfg_to_per = 0, cfg_inc = 1;
    logic        cfg_cont = 0, cfg_pingpong = 0, cfg_half = 0;
    logic [4:0]  cfg_sel = 5'd5;
    logic [9:0]  cfg_len = '0;
    logic [10:0] cfg_start_a = '0, cfg_start_b = '0;
    logic        sw_force = 0;
    logic [31:0] req_lines = '0;
    logic        ram_req, ram_we, per_req, per_we;
    logic [10:0] ram_addr;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata, ram_rdata, per_wdata;
    logic [15:0] per_rdata = '0;
    logic        ram_stall = 0;
    logic        ram_rdy, per_rdy;
    logic        cpu_ram_we = 0, cpu_per_we = 0;
    logic        active, ppbuf, irq, err_ram, err_per;

    logic [15:0] mem [0:127];
    logic [15:0] per_last;
    int          wr_cnt, irq_cnt;
    logic        clr_mem = 0, ld_mem = 0;
    logic [6:0]  ld_idx = '0;
    logic [15:0] ld_val = '0;
    int          checks = 0, fails = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    assign ram_rdy   = ~ram_stall;
    assign per_rdy   = 1'b1;
    assign ram_rdata = mem[ram_addr[7:1]];

    dma_pp_channel i_dma_pp_channel (
        .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_byte(cfg_byte),
        .cfg_to_per(cfg_to_per), .cfg_inc(cfg_inc), .cfg_cont(cfg_cont),
        .cfg_pingpong(cfg_pingpong), .cfg_half(cfg_half), .cfg_sel(cfg_sel),
        .cfg_len(cfg_len), .cfg_start_a(cfg_start_a), .cfg_start_b(cfg_start_b),
        .sw_force(sw_force), .req_lines(req_lines),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_rdy(ram_rdy),
        .per_req(per_req), .per_we(per_we), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .per_rdy(per_rdy),
        .cpu_ram_we(cpu_ram_we), .cpu_per_we(cpu_per_we),
        .active(active), .ppbuf(ppbuf), .irq(irq), .err_ram(err_ram), .err_per(err_per));

    // Memory, peripheral register model and event counters.
    always @(posedge clk) begin
        if (clr_mem) begin
            for (int k = 0; k < 128; k++) mem[k] <= '0;
        end else if (ld_mem) begin
            mem[ld_idx] <= ld_val;
        end else if (ram_req && ram_we && ram_rdy) begin
            if (ram_be[0]) mem[ram_addr[7:1]][7:0]  <= ram_wdata[7:0];
            if (ram_be[1]) mem[ram_addr[7:1]][15:8] <= ram_wdata[15:8];
            wr_cnt <= wr_cnt + 1;
        end
        if (per_req && per_we && per_rdy) begin
            per_last <= per_wdata;
            wr_cnt   <= wr_cnt + 1;
        end
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    initial begin
        wr_cnt = 0; irq_cnt = 0; per_last = '0;
    end

    typedef struct packed {
        logic        bm;
        logic        inc;
        logic [3:0]  len;
        logic [7:0]  sta;
        logic [7:0]  chk_addr;
        logic [15:0] chk_word;
        logic [7:0]  zero_addr;
    } vec_t;

    // Peripheral-to-RAM one-shot blocks; the peripheral supplies A000+i.
    localparam vec_t VECS [0:3] = '{
        '{1'b0, 1'b1, 4'd3, 8'h10, 8'h16, 16'hA003, 8'h18},
        '{1'b1, 1'b1, 4'd3, 8'h21, 8'h22, 16'h0201, 8'h26},
        '{1'b0, 1'b0, 4'd2, 8'h30, 8'h30, 16'hA002, 8'h32},
        '{1'b1, 1'b0, 4'd1, 8'h41, 8'h40, 16'h0100, 8'h42}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input int line);
        req_lines = '0;
        req_lines[line] = 1'b1;
        @(negedge clk);
        req_lines = '0;
    endtask

    task automatic xfer(input int line);
        pulse_req(line);
        tick(5);
    endtask

    task automatic arm();
        cfg_arm = 1'b1;
        @(negedge clk);
        cfg_arm = 1'b0;
    endtask

    task automatic wipe();
        clr_mem = 1'b1;
        @(negedge clk);
        clr_mem = 1'b0;
    endtask

    task automatic setup(input logic bm, input logic tp, input logic inc, input logic cont,
                         input logic pp, input logic half, input int len,
                         input logic [10:0] sa, input logic [10:0] sb);
        cfg_byte = bm; cfg_to_per = tp; cfg_inc = inc; cfg_cont = cont;
        cfg_pingpong = pp; cfg_half = half; cfg_len = 10'(len);
        cfg_start_a = sa; cfg_start_b = sb;
        arm();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int w0, i0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 active", active, 0);
        chk("R1 irq", irq, 0);
        chk("R1 errs", {err_ram, err_per}, 0);
        chk("R1 ppbuf", ppbuf, 0);
        chk("R1 port reqs", {ram_req, per_req}, 0);

        // R2 R3 R5 R9: vector table of one-shot peripheral-to-RAM blocks
        for (int v = 0; v < 4; v++) begin
            wipe();
            setup(VECS[v].bm, 1'b0, VECS[v].inc, 1'b0, 1'b0, 1'b0,
                  int'(VECS[v].len), 11'(VECS[v].sta), 11'h0);
            i0 = irq_cnt;
            for (int i = 0; i <= int'(VECS[v].len); i++) begin
                per_rdata = 16'hA000 + 16'(i);
                xfer(5);
            end
            chk("R2 R3 written word", mem[VECS[v].chk_addr[7:1]], VECS[v].chk_word);
            chk("R2 R3 untouched word", mem[VECS[v].zero_addr[7:1]], 0);
            chk("R9 block end irq", irq_cnt - i0, 1);
            chk("R5 one-shot inactive", active, 0);
        end

        // R5 requests after a one-shot end are ignored
        w0 = wr_cnt;
        xfer(5);
        chk("R5 no transfer after end", wr_cnt - w0, 0);

        // R4 RAM to peripheral, byte lane and word
        ld_idx = 7'h40; ld_val = 16'h5AC3; ld_mem = 1'b1; tick(1); ld_mem = 1'b0;
        setup(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 11'h81, 11'h0);
        xfer(5);
        chk("R4 byte upper lane", per_last, 16'h005A);
        setup(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 11'h80, 11'h0);
        xfer(5);
        chk("R4 byte lower lane", per_last, 16'h00C3);
        setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 11'h80, 11'h0);
        xfer(5);
        chk("R4 word", per_last, 16'h5AC3);

        // R6 continuous reload
        wipe();
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1, 11'h70, 11'h0);
        per_rdata = 16'h1111; xfer(5);
        per_rdata = 16'h2222; xfer(5);
        per_rdata = 16'h3333; xfer(5);
        chk("R6 reload to start", mem[7'h38], 16'h3333);
        chk("R6 second slot", mem[7'h39], 16'h2222);
        chk("R6 still active", active, 1);

        // R7 continuous ping-pong
        wipe();
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1, 11'h50, 11'h60);
        per_rdata = 16'hB001; xfer(5);
        per_rdata = 16'hB002; xfer(5);
        chk("R7 ppbuf after A", ppbuf, 1);
        per_rdata = 16'hB003; xfer(5);
        per_rdata = 16'hB004; xfer(5);
        chk("R7 buffer B second", mem[7'h31], 16'hB004);
        chk("R7 ppbuf after B", ppbuf, 0);
        per_rdata = 16'hB005; xfer(5);
        chk("R7 back to A", mem[7'h28], 16'hB005);

        // R7 one-shot ping-pong stops after B
        setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1, 11'h50, 11'h60);
        xfer(5); xfer(5);
        chk("R7 active after A", active, 1);
        xfer(5); xfer(5);
        chk("R7 inactive after B", active, 0);

        // R9 half-block interrupt
        setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3, 11'h10, 11'h0);
        i0 = irq_cnt;
        xfer(5);
        chk("R9 no irq at index 0", irq_cnt - i0, 0);
        xfer(5);
        chk("R9 half irq at index 1", irq_cnt - i0, 1);
        xfer(5); xfer(5);
        chk("R9 no irq at end with half", irq_cnt - i0, 1);

        // R8 requests while inactive are dropped
        w0 = wr_cnt;
        pulse_req(5);
        tick(2);
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 15, 11'h10, 11'h0);
        tick(5);
        chk("R8 inactive request dropped", wr_cnt - w0, 0);

        // R8 trigger select and software force
        cfg_sel = 5'd7;
        xfer(6); xfer(8);
        chk("R8 other lines ignored", wr_cnt - w0, 0);
        xfer(7);
        chk("R8 selected line", wr_cnt - w0, 1);
        sw_force = 1'b1; tick(1); sw_force = 1'b0; tick(5);
        chk("R8 software force", wr_cnt - w0, 2);

        // R10 requests during a transfer are held as one
        w0 = wr_cnt;
        pulse_req(7); pulse_req(7); pulse_req(7);
        tick(8);
        chk("R10 one held request", wr_cnt - w0, 2);

        // R11 stalled RAM write holds
        wipe();
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 15, 11'h90, 11'h0);
        w0 = wr_cnt;
        ram_stall = 1'b1; per_rdata = 16'hC0DE;
        pulse_req(7);
        tick(6);
        chk("R11 no completion while stalled", wr_cnt - w0, 0);
        chk("R11 request held", ram_req, 1);
        chk("R11 address held", ram_addr, 11'h90);
        ram_stall = 1'b0;
        tick(4);
        chk("R11 completes after ready", mem[7'h48], 16'hC0DE);

        // R12 write collisions
        cpu_ram_we = 1'b1;
        pulse_req(7);
        tick(4);
        cpu_ram_we = 1'b0;
        tick(2);
        chk("R12 ram collision", err_ram, 1);
        chk("R12 no per collision", err_per, 0);
        arm();
        chk("R12 cleared by arm", err_ram, 0);
        setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 15, 11'h80, 11'h0);
        cpu_per_we = 1'b1;
        pulse_req(7);
        tick(4);
        cpu_per_we = 1'b0;
        tick(2);
        chk("R12 per collision", err_per, 1);
        chk("R12 sticky", err_per, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule